// File: doc/BRIEF.md
# Delay-Slot Next-Fetch Address Unit

This block works out where instruction fetch goes after a control-transfer instruction in a core with one branch delay slot. When a transfer is accepted, it gives the address of the delay-slot instruction and the address that fetch redirects to once that slot has run. For the "likely" branch form, it also tells the pipeline to squash the delay slot. For the two linking jumps, it produces a register write: the destination register number and the return address.

The block tracks the delay slot with a two-state machine. **IDLE** means no transfer is outstanding. **SLOT** means a transfer has been accepted and its delay-slot instruction has not yet been presented. These transitions exist:

- **ISSUE** (IDLE to SLOT): a valid transfer arrives in IDLE.
- **DRAIN** (SLOT to IDLE): any valid instruction arrives in SLOT. If that instruction is itself a transfer, the block flags it as illegal and does not act on it.
- **HOLD** (stay in the current state): no valid instruction is presented.

The branch condition is evaluated upstream and arrives as a single bit. Every result appears on registered outputs one clock after the instruction is presented.

Top module: `npc_unit`

## Requirements
- R1: After reset, `res_valid`, `illegal`, `nullify`, `link_we` and `slot_pending` are all 0.
- R2: For a conditional branch (`cls`=1) or a likely branch (`cls`=2) with `cond`=1, `slot_pc` is pc+4 and `next_pc` is pc+4 plus the sign-extended `br_off` shifted left by two.
- R3: For a conditional branch (`cls`=1) with `cond`=0, `next_pc` is pc+8 and `nullify` is 0.
- R4: For a likely branch (`cls`=2), `nullify` is 1 exactly when `cond`=0. In that case `next_pc` is pc+8. No other class ever raises `nullify`.
- R5: For a direct jump (`cls`=3), `next_pc` is bits [31:28] of pc+4, then `jmp_idx`, then two zero bits. No link write is made.
- R6: For a linking direct jump (`cls`=4), `next_pc` is formed as in R5, `link_we`=1, `link_rd`=31 and `link_val`=pc+8.
- R7: For a register jump (`cls`=5), `next_pc` equals `reg_tgt` and `link_we` is 0.
- R8: For a linking register jump (`cls`=6), `next_pc` equals `reg_tgt`, `link_we`=1, `link_rd` equals `link_rd_in` and `link_val`=pc+8.
- R9: A transfer presented while `slot_pending`=1 produces a one-cycle `illegal` pulse and no `res_valid`, and the state returns to IDLE.
- R10: Cycles with `instr_valid`=0 change nothing. A valid non-transfer (`cls`=0 or 7) in IDLE produces no output.
- R11: Every accepted transfer yields exactly one `res_valid` pulse, one cycle after it is presented. `res_valid` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| cls | input | 3 | Class: 0 none, 1 branch, 2 likely branch, 3 jump, 4 linking jump, 5 register jump, 6 linking register jump, 7 none |
| pc | input | 32 | Address of the presented instruction |
| cond | input | 1 | Branch condition result |
| br_off | input | 16 | Signed branch word offset |
| jmp_idx | input | 26 | Jump word index |
| reg_tgt | input | 32 | Register-supplied jump target |
| link_rd_in | input | 5 | Link destination for the linking register jump |
| res_valid | output | 1 | Transfer result valid (one-cycle pulse) |
| slot_pc | output | 32 | Delay-slot address |
| next_pc | output | 32 | Fetch address after the delay slot |
| nullify | output | 1 | Squash the delay slot |
| link_we | output | 1 | Link register write enable |
| link_rd | output | 5 | Link destination register |
| link_val | output | 32 | Return address to write |
| illegal | output | 1 | Transfer presented in a delay slot |
| slot_pending | output | 1 | The machine is in SLOT |

## Verification
The bench aims at several corner cases:

- A negative offset must borrow through the full address. A design that zero-extends the offset sends the branch far forward instead.
- A jump issued just below a 256 MiB boundary takes its upper bits from pc+4, not from pc. Using pc leaves the target in the wrong region.
- Likely branches are run both taken and not taken. A swapped polarity squashes the wrong delay slots.
- Back-to-back transfers are presented, including with idle cycles between them. A design that forgets the pending slot, or drops it on an idle cycle, acts on a second branch that must be rejected.

// File: rtl/npc_pkg.sv
package npc_pkg;

    typedef enum logic [2:0] {
        CLS_NONE  = 3'd0,
        CLS_BR    = 3'd1,
        CLS_BRL   = 3'd2,
        CLS_J     = 3'd3,
        CLS_JAL   = 3'd4,
        CLS_JR    = 3'd5,
        CLS_JALR  = 3'd6,
        CLS_RSVD  = 3'd7
    } xfer_cls_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SLOT = 1'b1
    } slot_state_e;

    function automatic logic is_xfer(input logic [2:0] c);
        logic r;
        unique case (c)
            CLS_BR, CLS_BRL, CLS_J, CLS_JAL, CLS_JR, CLS_JALR: r = 1'b1;
            default:                                          r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/npc_target_calc.sv
module npc_target_calc
    import npc_pkg::*;
#(
    parameter int AW    = 32,
    parameter int OFF_W = 16,
    parameter int IDX_W = 26
) (
    input  logic [2:0]       cls,
    input  logic [AW-1:0]    pc,
    input  logic             cond,
    input  logic [OFF_W-1:0] br_off,
    input  logic [IDX_W-1:0] jmp_idx,
    input  logic [AW-1:0]    reg_tgt,
    output logic [AW-1:0]    slot_pc,
    output logic [AW-1:0]    next_pc,
    output logic             nullify
);
    localparam int SEXT_W = AW - OFF_W - 2;
    localparam int HI_W   = AW - IDX_W - 2;
    localparam logic [AW-1:0] STEP4 = AW'(4);
    localparam logic [AW-1:0] STEP8 = AW'(8);

    logic [AW-1:0] pc_p4;
    logic [AW-1:0] pc_p8;
    logic [AW-1:0] br_disp;
    logic [AW-1:0] br_tgt;
    logic [AW-1:0] jmp_tgt;

    always_comb begin
        pc_p4   = pc + STEP4;
        pc_p8   = pc + STEP8;
        br_disp = {{SEXT_W{br_off[OFF_W-1]}}, br_off, 2'b00};
        br_tgt  = pc_p4 + br_disp;
        jmp_tgt = {pc_p4[AW-1 -: HI_W], jmp_idx, 2'b00};
    end

    always_comb begin
        slot_pc = pc_p4;
        next_pc = pc_p8;
        nullify = 1'b0;
        unique case (cls)
            CLS_BR: begin
                next_pc = cond ? br_tgt : pc_p8;
            end
            CLS_BRL: begin
                next_pc = cond ? br_tgt : pc_p8;
                nullify = ~cond;
            end
            CLS_J, CLS_JAL: begin
                next_pc = jmp_tgt;
            end
            CLS_JR, CLS_JALR: begin
                next_pc = reg_tgt;
            end
            default: begin
                next_pc = pc_p8;
            end
        endcase
    end

endmodule

// File: rtl/npc_link_gen.sv
module npc_link_gen
    import npc_pkg::*;
#(
    parameter int AW       = 32,
    parameter int RN_W     = 5,
    parameter int LINK_REG = 31
) (
    input  logic [2:0]      cls,
    input  logic [AW-1:0]   pc,
    input  logic [RN_W-1:0] link_rd_in,
    output logic            link_we,
    output logic [RN_W-1:0] link_rd,
    output logic [AW-1:0]   link_val
);
    localparam logic [AW-1:0]   STEP8   = AW'(8);
    localparam logic [RN_W-1:0] RA_IDX  = RN_W'(LINK_REG);

    always_comb begin
        link_val = pc + STEP8;
        link_we  = 1'b0;
        link_rd  = '0;
        unique case (cls)
            CLS_JAL: begin
                link_we = 1'b1;
                link_rd = RA_IDX;
            end
            CLS_JALR: begin
                link_we = 1'b1;
                link_rd = link_rd_in;
            end
            default: begin
                link_we = 1'b0;
                link_rd = '0;
            end
        endcase
    end

endmodule

// File: rtl/npc_slot_fsm.sv
module npc_slot_fsm
    import npc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic instr_valid,
    input  logic xfer,
    output logic issue,
    output logic reject,
    output logic pending
);
    slot_state_e state_q;
    slot_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        issue   = 1'b0;
        reject  = 1'b0;
        pending = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (instr_valid && xfer) begin
                    issue   = 1'b1;
                    state_d = ST_SLOT;
                end
            end
            ST_SLOT: begin
                pending = 1'b1;
                if (instr_valid) begin
                    reject  = xfer;
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int AW       = 32,
    parameter int OFF_W    = 16,
    parameter int IDX_W    = 26,
    parameter int RN_W     = 5,
    parameter int LINK_REG = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid,
    input  logic [2:0]       cls,
    input  logic [AW-1:0]    pc,
    input  logic             cond,
    input  logic [OFF_W-1:0] br_off,
    input  logic [IDX_W-1:0] jmp_idx,
    input  logic [AW-1:0]    reg_tgt,
    input  logic [RN_W-1:0]  link_rd_in,
    output logic             res_valid,
    output logic [AW-1:0]    slot_pc,
    output logic [AW-1:0]    next_pc,
    output logic             nullify,
    output logic             link_we,
    output logic [RN_W-1:0]  link_rd,
    output logic [AW-1:0]    link_val,
    output logic             illegal,
    output logic             slot_pending
);
    logic            xfer;
    logic            issue;
    logic            reject;
    logic [AW-1:0]   c_slot;
    logic [AW-1:0]   c_next;
    logic            c_null;
    logic            c_lwe;
    logic [RN_W-1:0] c_lrd;
    logic [AW-1:0]   c_lval;

    assign xfer = is_xfer(cls);

    npc_slot_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .xfer        (xfer),
        .issue       (issue),
        .reject      (reject),
        .pending     (slot_pending)
    );

    npc_target_calc #(
        .AW    (AW),
        .OFF_W (OFF_W),
        .IDX_W (IDX_W)
    ) u_tgt (
        .cls     (cls),
        .pc      (pc),
        .cond    (cond),
        .br_off  (br_off),
        .jmp_idx (jmp_idx),
        .reg_tgt (reg_tgt),
        .slot_pc (c_slot),
        .next_pc (c_next),
        .nullify (c_null)
    );

    npc_link_gen #(
        .AW       (AW),
        .RN_W     (RN_W),
        .LINK_REG (LINK_REG)
    ) u_link (
        .cls        (cls),
        .pc         (pc),
        .link_rd_in (link_rd_in),
        .link_we    (c_lwe),
        .link_rd    (c_lrd),
        .link_val   (c_lval)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            illegal   <= 1'b0;
            slot_pc   <= '0;
            next_pc   <= '0;
            nullify   <= 1'b0;
            link_we   <= 1'b0;
            link_rd   <= '0;
            link_val  <= '0;
        end else begin
            res_valid <= issue;
            illegal   <= reject;
            nullify   <= issue & c_null;
            link_we   <= issue & c_lwe;
            if (issue) begin
                slot_pc  <= c_slot;
                next_pc  <= c_next;
                link_rd  <= c_lrd;
                link_val <= c_lval;
            end
        end
    end

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
    import npc_pkg::*;
#(
    parameter int AW   = 32,
    parameter int RN_W = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic [2:0]      cls,
    input logic [AW-1:0]   pc,
    input logic            cond,
    input logic            res_valid,
    input logic [AW-1:0]   slot_pc,
    input logic [AW-1:0]   next_pc,
    input logic            nullify,
    input logic            link_we,
    input logic [RN_W-1:0] link_rd,
    input logic            illegal,
    input logic            slot_pending
);
    localparam logic [AW-1:0] K4 = AW'(4);
    localparam logic [AW-1:0] K8 = AW'(8);

    // R11
    res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R2
    slot_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> slot_pc == $past(pc) + K4);

    // R3
    fallthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(cls) == CLS_BR && !$past(cond)) |-> (next_pc == $past(pc) + K8 && !nullify));

    // R4
    squash_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nullify |-> (res_valid && $past(cls) == CLS_BRL && !$past(cond)));

    // R7
    jr_nolink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(cls) == CLS_JR) |-> !link_we);

    // R9
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!res_valid && $past(slot_pending) && !slot_pending));

    // R6
    ra_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_we && $past(cls) == CLS_JAL) |-> link_rd == RN_W'(31));

endmodule

bind npc_unit npc_unit_chk #(.AW(AW), .RN_W(RN_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cls          (cls),
    .pc           (pc),
    .cond         (cond),
    .res_valid    (res_valid),
    .slot_pc      (slot_pc),
    .next_pc      (next_pc),
    .nullify      (nullify),
    .link_we      (link_we),
    .link_rd      (link_rd),
    .illegal      (illegal),
    .slot_pending (slot_pending)
);

// File: tb/npc_unit_tb.sv
module npc_unit_tb_top;

    typedef struct {
        bit          is_ill;
        logic [31:0] slot;
        logic [31:0] nxt;
        bit          nul;
        bit          lwe;
        logic [4:0]  lrd;
        logic [31:0] lval;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [2:0]  cls = '0;
    logic [31:0] pc = '0;
    logic        cond = 1'b0;
    logic [15:0] br_off = '0;
    logic [25:0] jmp_idx = '0;
    logic [31:0] reg_tgt = '0;
    logic [4:0]  link_rd_in = '0;
    logic        res_valid;
    logic [31:0] slot_pc;
    logic [31:0] next_pc;
    logic        nullify;
    logic        link_we;
    logic [4:0]  link_rd;
    logic [31:0] link_val;
    logic        illegal;
    logic        slot_pending;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   pend  = 0;
    exp_t q[$];

    always #10 clk = ~clk;

    npc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .cls(cls), .pc(pc),
        .cond(cond), .br_off(br_off), .jmp_idx(jmp_idx), .reg_tgt(reg_tgt),
        .link_rd_in(link_rd_in), .res_valid(res_valid), .slot_pc(slot_pc),
        .next_pc(next_pc), .nullify(nullify), .link_we(link_we), .link_rd(link_rd),
        .link_val(link_val), .illegal(illegal), .slot_pending(slot_pending)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic bit xfer_cls(input logic [2:0] c);
        return (c >= 3'd1) && (c <= 3'd6);
    endfunction

    task automatic send(input logic [2:0] c, input logic [31:0] p, input logic cd,
                        input logic [15:0] off, input logic [25:0] idx,
                        input logic [31:0] tgt, input logic [4:0] rd, input string tag);
        exp_t e;
        @(negedge clk);
        instr_valid = 1'b1; cls = c; pc = p; cond = cd;
        br_off = off; jmp_idx = idx; reg_tgt = tgt; link_rd_in = rd;
        if (xfer_cls(c)) begin
            e.tag = tag; e.is_ill = pend; e.nul = 0; e.lwe = 0; e.lrd = 0;
            e.slot = p + 32'd4; e.lval = p + 32'd8; e.nxt = p + 32'd8;
            if (!pend) begin
                case (c)
                    3'd1, 3'd2: begin
                        if (cd) e.nxt = p + 32'd4 + {{14{off[15]}}, off, 2'b00};
                        e.nul = (c == 3'd2) && !cd;
                    end
                    3'd3, 3'd4: begin
                        e.nxt = ((p + 32'd4) & 32'hF000_0000) | ({6'd0, idx} << 2);
                        if (c == 3'd4) begin e.lwe = 1; e.lrd = 5'd31; end
                    end
                    default: begin
                        e.nxt = tgt;
                        if (c == 3'd6) begin e.lwe = 1; e.lrd = rd; end
                    end
                endcase
            end
            q.push_back(e);
            pend = !pend;
        end else begin
            pend = 0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            instr_valid = 1'b0;
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && (res_valid || illegal)) begin
            if (q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R10/R11 unexpected output: actual res_valid=%0b illegal=%0b expected none",
                         res_valid, illegal);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, "illegal", {31'd0, illegal}, {31'd0, e.is_ill});
                check(e.tag, "res_valid", {31'd0, res_valid}, {31'd0, !e.is_ill});
                if (!e.is_ill) begin
                    check(e.tag, "slot_pc", slot_pc, e.slot);
                    check(e.tag, "next_pc", next_pc, e.nxt);
                    check(e.tag, "nullify", {31'd0, nullify}, {31'd0, e.nul});
                    check(e.tag, "link_we", {31'd0, link_we}, {31'd0, e.lwe});
                    if (e.lwe) begin
                        check(e.tag, "link_rd", {27'd0, link_rd}, {27'd0, e.lrd});
                        check(e.tag, "link_val", link_val, e.lval);
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "res_valid", {31'd0, res_valid}, 32'd0);
        check("R1", "illegal", {31'd0, illegal}, 32'd0);
        check("R1", "nullify", {31'd0, nullify}, 32'd0);
        check("R1", "link_we", {31'd0, link_we}, 32'd0);
        check("R1", "slot_pending", {31'd0, slot_pending}, 32'd0);
        rst_n = 1'b1;
        idle(2);

        // R2 taken branch, forward and negative offsets
        send(3'd1, 32'h0000_1000, 1, 16'h0010, 0, 0, 0, "R2");
        send(3'd0, 32'h0000_1004, 0, 0, 0, 0, 0, "R2");
        send(3'd1, 32'h0000_1000, 1, 16'hFFFE, 0, 0, 0, "R2");
        send(3'd0, 32'h0000_1004, 0, 0, 0, 0, 0, "R2");
        // R3 not taken
        send(3'd1, 32'h0000_2000, 0, 16'h7FFF, 0, 0, 0, "R3");
        send(3'd0, 32'h0000_2004, 0, 0, 0, 0, 0, "R3");
        // R4 likely taken / not taken
        send(3'd2, 32'h0001_0000, 1, 16'h8000, 0, 0, 0, "R4");
        send(3'd0, 32'h0001_0004, 0, 0, 0, 0, 0, "R4");
        send(3'd2, 32'h0001_0000, 0, 16'h0020, 0, 0, 0, "R4");
        send(3'd0, 32'h0001_0004, 0, 0, 0, 0, 0, "R4");
        // R5 jump across region boundary
        send(3'd3, 32'h8FFF_FFFC, 0, 0, 26'h3FF_FFFF, 0, 0, "R5");
        send(3'd0, 32'h9000_0000, 0, 0, 0, 0, 0, "R5");
        // R6 linking jump
        send(3'd4, 32'h0040_0100, 0, 0, 26'h000_0123, 0, 0, "R6");
        send(3'd0, 32'h0040_0104, 0, 0, 0, 0, 0, "R6");
        // R7 register jump
        send(3'd5, 32'h0000_3000, 1, 0, 0, 32'hDEAD_BEE0, 5'd9, "R7");
        send(3'd0, 32'h0000_3004, 0, 0, 0, 0, 0, "R7");
        // R8 linking register jump
        send(3'd6, 32'h0000_4000, 0, 0, 0, 32'h1234_5678, 5'd7, "R8");
        send(3'd0, 32'h0000_4004, 0, 0, 0, 0, 0, "R8");
        // R9 transfer in delay slot, then a fresh branch is accepted
        send(3'd1, 32'h0000_5000, 1, 16'h0004, 0, 0, 0, "R9");
        send(3'd3, 32'h0000_5004, 0, 0, 26'h00_0040, 0, 0, "R9");
        send(3'd0, 32'h0000_5008, 0, 0, 0, 0, 0, "R9");
        send(3'd1, 32'h0000_500C, 0, 16'h0004, 0, 0, 0, "R9");
        send(3'd0, 32'h0000_5010, 0, 0, 0, 0, 0, "R9");
        // R10 idle cycles keep the slot pending; transfer afterwards is rejected
        send(3'd5, 32'h0000_6000, 0, 0, 0, 32'h0000_7000, 0, "R10");
        idle(3);
        check("R10", "slot_pending", {31'd0, slot_pending}, 32'd1);
        send(3'd6, 32'h0000_6004, 0, 0, 0, 32'h0000_8000, 5'd3, "R10");
        // R10 non-transfers in IDLE produce nothing
        send(3'd0, 32'h0000_9000, 1, 0, 0, 0, 0, "R10");
        send(3'd7, 32'h0000_9004, 1, 0, 0, 0, 0, "R10");
        idle(3);
        check("R10", "slot_pending", {31'd0, slot_pending}, 32'd0);
        // R11 every expected pulse consumed
        check("R11", "pending expectations", q.size(), 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule